// File: doc/BRIEF.md
# Order-Preserving Stream Compaction Filter

The block takes a block of eight 16-bit elements together with a criterion select and returns a packed array holding only the elements that pass the criterion, in their original order. Two criteria are offered: keep elements whose value is odd, or keep elements equal to a search key supplied with the block. Every element gets a one-bit keep flag. The exclusive prefix sum of those flags gives each kept element its destination slot. The kept elements are then scattered to those slots in a single cycle.

A load strobe captures the input vector, the mode and the key. The block then walks the keep flags one element per cycle to build the prefix sums. It writes the packed vector and the kept count, and raises valid for one cycle. The packed vector and the count stay unchanged until the next result is written. A load that arrives while a block is in flight is dropped.

Element i occupies bits [16*i+15 : 16*i] of both the input and the output vector, so element 0 is in the lowest bits.

Top module: `stream_compactor`

## Requirements
- R1: With `match_mode` = 0, an element is kept exactly when its bit 0 is 1 (its value mod 2 is 1).
- R2: With `match_mode` = 1, an element is kept exactly when it equals `key`. Mode and key are sampled with the load.
- R3: Kept elements appear in the output in input order. A kept element i lands in output slot p(i), where p(i) is the number of kept elements with index below i. For input [2,3,8,7,6,2,1,5] in odd mode, the output is [3,7,1,5,0,0,0,0].
- R4: `count` equals the number of kept elements, from 0 to 8. It equals the last prefix value plus the last keep flag.
- R5: Output slots with an index at or beyond `count` are zero.
- R6: `valid` is high for exactly one cycle. That cycle follows the (N+1)-th rising edge after the edge that samples `load`, with N = 8.
- R7: A `load` sampled from the accepting edge through the valid cycle, inclusive, is ignored. `dout` and `count` hold their last result between valid pulses.
- R8: After reset, `dout` and `count` are zero and `valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Strobe that captures a new block when idle |
| match_mode | input | 1 | 0 keeps odd values, 1 keeps values equal to `key` |
| key | input | 16 | Search key for the equality criterion |
| din | input | 128 | Eight input elements, element 0 in the low bits |
| dout | output | 128 | Packed kept elements, zero-filled at the top |
| count | output | 4 | Number of kept elements |
| valid | output | 1 | One-cycle pulse marking a new result |

## Verification
The worked odd-value example is run first because it pins the slot mapping to the exclusive prefix sum. All-odd and all-even blocks then cover the extremes of the count, 8 and 0, and the zero fill of an empty result. Alternating and clustered patterns show whether order is kept when gaps fall at different places. Equality mode is run with a key that matches some elements, none, and every element, and with data whose odd/even pattern differs from the match pattern, so a mode mix-up shows. Loads issued in the middle of a scan and during the valid cycle show whether busy-time loads are dropped rather than corrupting or restarting the result.

// File: rtl/stream_compactor.sv
module stream_compactor #(
  parameter int N = 8,
  parameter int W = 16,
  localparam int CW = $clog2(N + 1),
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           match_mode,
  input  logic [W-1:0]   key,
  input  logic [N*W-1:0] din,
  output logic [N*W-1:0] dout,
  output logic [CW-1:0]  count,
  output logic           valid
);

  typedef enum logic [1:0] {IDLE, SCAN, PACK, DONE} state_t;

  state_t        st;
  logic [W-1:0]  elem [N];
  logic [N-1:0]  keep, keep_in;
  logic [CW-1:0] pos  [N];
  logic [CW-1:0] run;
  logic [IW-1:0] idx;
  logic [N*W-1:0] packed_v;

  for (genvar i = 0; i < N; i++) begin : g_flag
    assign keep_in[i] = match_mode ? (din[i*W +: W] == key) : din[i*W];
  end

  always_comb begin
    packed_v = '0;
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        if (keep[i] && pos[i] == CW'(j))
          packed_v[j*W +: W] = elem[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      keep  <= '0;
      run   <= '0;
      idx   <= '0;
      dout  <= '0;
      count <= '0;
      for (int i = 0; i < N; i++) begin
        elem[i] <= '0;
        pos[i]  <= '0;
      end
    end else begin
      case (st)
        IDLE: if (load) begin
          for (int i = 0; i < N; i++) elem[i] <= din[i*W +: W];
          keep <= keep_in;
          run  <= '0;
          idx  <= '0;
          st   <= SCAN;
        end
        SCAN: begin
          pos[idx] <= run;
          run      <= run + CW'(keep[idx]);
          if (idx == IW'(N - 1)) st <= PACK;
          else idx <= idx + 1'b1;
        end
        PACK: begin
          dout  <= packed_v;
          count <= run;
          st    <= DONE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign valid = (st == DONE);

  assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  assert_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (count <= CW'(N)) && (count == CW'($countones(keep))));

  assert_busy_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && st != IDLE) |=> $stable(keep));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SCAN) |=> $stable(dout) && $stable(count));

  for (genvar j = 0; j < N; j++) begin : g_chk
    assert_zero_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && count <= CW'(j)) |-> (dout[j*W +: W] == '0));
    if (j > 0) begin : g_ord
      assert_prefix_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> pos[j] == pos[j-1] + CW'(keep[j-1]));
    end
  end

endmodule

// File: tb/tb_stream_compactor.sv
`timescale 1ns/1ps
module tb_stream_compactor;
  localparam int N = 8;
  localparam int W = 16;
  localparam int CW = $clog2(N + 1);

  logic clk = 0, rst_n = 0, load = 0, match_mode = 0;
  logic [W-1:0] key = '0;
  logic [N*W-1:0] din = '0, dout;
  logic [CW-1:0] count;
  logic valid;

  int checks = 0, errors = 0, cyc = 0;

  logic [N*W-1:0] q_dout[$];
  int             q_cnt[$];
  int             q_cyc[$];
  string          q_tag[$];
  logic [N*W-1:0] last_dout;
  int             last_cnt;

  stream_compactor #(.N(N), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .load(load), .match_mode(match_mode),
    .key(key), .din(din), .dout(dout), .count(count), .valid(valid));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [N*W-1:0] mk(input int a0, a1, a2, a3, a4, a5, a6, a7);
    int v[N];
    logic [N*W-1:0] r;
    v = '{a0, a1, a2, a3, a4, a5, a6, a7};
    for (int i = 0; i < N; i++) r[i*W +: W] = W'(v[i]);
    return r;
  endfunction

  task automatic check(input string req, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input string tag, input logic m, input logic [W-1:0] k,
                       input logic [N*W-1:0] v, input bit expect_accept);
    logic [N*W-1:0] e;
    int wp;
    @(negedge clk);
    din = v; match_mode = m; key = k; load = 1;
    if (expect_accept) begin
      e = '0; wp = 0;
      for (int i = 0; i < N; i++)
        if (m ? (v[i*W +: W] == k) : (v[i*W +: W] % 2 == 1)) begin
          e[wp*W +: W] = v[i*W +: W];
          wp++;
        end
      q_dout.push_back(e); q_cnt.push_back(wp);
      q_cyc.push_back(cyc + N + 2); q_tag.push_back(tag);
    end
    @(negedge clk);
    load = 0;
  endtask

  task automatic settle();
    repeat (N + 5) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (q_dout.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7: actual unexpected valid, expected none (busy load must be dropped)");
      end else begin
        string t;
        t = q_tag.pop_front();
        check({t, " R3 R5 dout"}, dout, q_dout.pop_front());
        check({t, " R4 count"}, N*W'(count), N*W'(q_cnt.pop_front()));
        check({t, " R6 latency"}, N*W'(cyc), N*W'(q_cyc.pop_front()));
        last_dout = dout; last_cnt = count;
      end
    end
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8 dout", dout, '0);
    check("R8 count", N*W'(count), '0);
    check("R8 valid", N*W'(valid), '0);

    issue("R1 worked example", 0, 0, mk(2,3,8,7,6,2,1,5), 1); settle();
    check("R7 hold dout", dout, last_dout);
    check("R7 hold count", N*W'(count), N*W'(last_cnt));
    issue("R1 all odd", 0, 0, mk(1,3,5,7,9,11,13,15), 1); settle();
    issue("R1 R5 all even", 0, 0, mk(0,2,4,6,8,10,12,14), 1); settle();
    issue("R1 alternating", 0, 0, mk(4,9,16,25,36,49,64,81), 1); settle();
    issue("R1 tail cluster", 0, 0, mk(2,2,2,2,2,65535,32769,3), 1); settle();
    issue("R2 some match", 1, 16'h00AA, mk(8'hAA,1,8'hAA,3,8'hAA,5,7,8'hAA), 1); settle();
    issue("R2 no match", 1, 16'h1234, mk(1,3,5,7,9,11,13,15), 1); settle();
    issue("R2 all match", 1, 16'hBEEF, mk(16'hBEEF,16'hBEEF,16'hBEEF,16'hBEEF,
                                          16'hBEEF,16'hBEEF,16'hBEEF,16'hBEEF), 1); settle();
    issue("R2 even key", 1, 16'd6, mk(6,1,3,6,5,6,7,9), 1); settle();

    issue("R7 first", 0, 0, mk(1,2,3,4,5,6,7,8), 1);
    repeat (2) @(negedge clk);
    issue("R7 dropped", 0, 0, mk(9,9,9,9,9,9,9,9), 0);
    settle();

    issue("R7 before done", 1, 16'd5, mk(5,0,5,0,0,0,0,5), 1);
    while (!valid) @(negedge clk);
    din = mk(7,7,7,7,7,7,7,7); match_mode = 0; load = 1;
    @(negedge clk); load = 0;
    settle();
    check("R7 hold after drop", dout, last_dout);

    issue("R3 back to back", 0, 0, mk(11,0,0,13,0,15,0,0), 1); settle();

    checks++;
    if (q_dout.size() != 0) begin
      errors++;
      $display("FAIL R6: actual %0d pending results, expected 0", q_dout.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule